// File: doc/BRIEF.md
# Fixed-Point Audio Arithmetic Unit

This unit is the arithmetic core of a small audio signal processor. On each instruction it takes a 4-bit opcode and three signed 32-bit operands, named A, X and Y, and returns a 32-bit result. The result is combinational and is valid in the same cycle the operands are driven.

The unit covers several families of operations:
- multiply-accumulate on Q31 fractions and on integers, each in a saturating form and a wrapping form;
- a three-input add;
- an and-then-xor bit operation;
- three compare-and-select operations;
- a linear interpolation step.

It also keeps a 64-bit multiply accumulator, which one opcode feeds while that opcode returns A unchanged. A condition-code word describes the last result taken.

Operand fetch, register storage, skip sequencing, log and exp conversion and delay memory are handled by neighbouring blocks. The opcodes that belong to those blocks pass A straight through.

The accumulator and the condition word are registered. They update only on a clock edge where `en` is high. The sequencer drives `en` once per issued instruction.

Top module: `fx_alu`

## Requirements
- R1: Opcodes 0x0..0x3 form a fractional product P = (X*Y) >>> 31, where the shift is arithmetic and so rounds toward minus infinity. Opcodes 0x0 and 0x2 give A + P. Opcodes 0x1 and 0x3 give A - P. Opcodes 0x0 and 0x1 saturate; 0x2 and 0x3 keep the low 32 bits.
- R2: Opcode 0x4 gives A + X*Y as a full integer product, saturated. Opcode 0x5 takes the same sum and keeps bits 30..0, with bit 31 a copy of bit 30. This wraps within 31 bits.
- R3: Opcode 0x6 gives A + X + Y, saturated.
- R4: Opcode 0x7 returns R = A. When `en` is high it adds (X*Y) >>> 31, sign-extended, into the 64-bit accumulator, which wraps on overflow. No other opcode changes the accumulator.
- R5: Opcode 0x8 gives (A & X) ^ Y.
- R6: All comparisons are signed. Opcode 0x9 returns X when A >= Y and ~X otherwise. Opcode 0xA returns X when A >= Y and Y otherwise. Opcode 0xB returns X when A < Y and Y otherwise.
- R7: Opcode 0xE gives A + ((X * (Y - A)) >>> 31), saturated. The difference Y - A is kept at full 33-bit precision.
- R8: Opcodes 0xC, 0xD and 0xF return R = A and leave the accumulator unchanged.
- R9: A saturating opcode clamps an out-of-range sum to 0x7FFFFFFF or 0x80000000. Condition bit 4 is set exactly when such a clamp occurs.
- R10: Condition bits 5..7 are always 0. The other bits are:

  | Bit | Meaning |
  |-----|---------|
  | 0 | R[31] differs from R[30] |
  | 1 | signed A < signed Y |
  | 2 | R[31] |
  | 3 | R == 0 |
  | 8 | R != 0 |
- R11: The condition word and the accumulator load only on a clock edge with `en` high. With `en` low both hold, while `result` still follows the inputs.
- R12: A clock edge with `rst` high clears the accumulator and the condition word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Commit strobe for accumulator and condition word |
| opcode | input | 4 | Operation select |
| opA | input | 32 | Operand A, signed |
| opX | input | 32 | Operand X, signed |
| opY | input | 32 | Operand Y, signed |
| result | output | 32 | Combinational result R |
| condCode | output | 9 | Registered condition word |
| accum | output | 64 | Registered multiply accumulator |

## Verification
A wrong accumulator value is visible on `accum` one edge after the offending `en` cycle. It then persists, so every later accumulate check also reports it. A wrong condition word appears on `condCode` at the edge after the instruction that produced it, and is compared against flags worked out by hand from the result and the operands. A faulty saturation or wrap choice shows on `result` immediately, in the same cycle, because the result path holds no state. The bench samples that path before the edge, and it samples the registered outputs after the edge.

// File: rtl/fx_alu_pkg.sv
package fx_alu_pkg;

  localparam int CC_W       = 9;
  localparam int CC_NORM    = 0;
  localparam int CC_BORROW  = 1;
  localparam int CC_MINUS   = 2;
  localparam int CC_ZERO    = 3;
  localparam int CC_SAT     = 4;
  localparam int CC_NONZERO = 8;

  typedef enum logic [1:0] {
    SRC_ARITH = 2'd0,
    SRC_LOGIC = 2'd1,
    SRC_CMP   = 2'd2,
    SRC_PASS  = 2'd3
  } srcSel_t;

  // Strobes from decode to datapath
  typedef struct packed {
    srcSel_t src;
    logic    useDiff;    // multiplier operand is Y - A
    logic    fracShift;  // Q31 product scaling
    logic    negTerm;    // subtract the product term
    logic    addMode;    // term is X + Y instead of a product
    logic    saturate;   // clamp to signed range
    logic    narrow;     // wrap within 31 bits
    logic    cmpLess;    // select X when A < Y (else when A >= Y)
    logic    altInv;     // alternate choice is ~X (else Y)
    logic    accLoad;    // accumulate fractional product
  } ctrl_t;

endpackage

// File: rtl/fx_alu_ctrl.sv
module fx_alu_ctrl
  import fx_alu_pkg::*;
(
  input  logic [3:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl     = '0;
    ctrl.src = SRC_PASS;
    unique case (opcode)
      4'h0: begin ctrl.src = SRC_ARITH; ctrl.fracShift = 1'b1; ctrl.saturate = 1'b1; end
      4'h1: begin ctrl.src = SRC_ARITH; ctrl.fracShift = 1'b1; ctrl.negTerm = 1'b1;
                  ctrl.saturate = 1'b1; end
      4'h2: begin ctrl.src = SRC_ARITH; ctrl.fracShift = 1'b1; end
      4'h3: begin ctrl.src = SRC_ARITH; ctrl.fracShift = 1'b1; ctrl.negTerm = 1'b1; end
      4'h4: begin ctrl.src = SRC_ARITH; ctrl.saturate = 1'b1; end
      4'h5: begin ctrl.src = SRC_ARITH; ctrl.narrow = 1'b1; end
      4'h6: begin ctrl.src = SRC_ARITH; ctrl.addMode = 1'b1; ctrl.saturate = 1'b1; end
      4'h7: begin ctrl.src = SRC_PASS; ctrl.fracShift = 1'b1; ctrl.accLoad = 1'b1; end
      4'h8: begin ctrl.src = SRC_LOGIC; end
      4'h9: begin ctrl.src = SRC_CMP; ctrl.altInv = 1'b1; end
      4'hA: begin ctrl.src = SRC_CMP; end
      4'hB: begin ctrl.src = SRC_CMP; ctrl.cmpLess = 1'b1; end
      4'hE: begin ctrl.src = SRC_ARITH; ctrl.useDiff = 1'b1; ctrl.fracShift = 1'b1;
                  ctrl.saturate = 1'b1; end
      default: ctrl.src = SRC_PASS;  // 0xC, 0xD, 0xF handled elsewhere
    endcase
  end

endmodule

// File: rtl/fx_alu_dp.sv
module fx_alu_dp
  import fx_alu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int ACC_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  ctrl_t            ctrl,
  input  logic [DW-1:0]    opA,
  input  logic [DW-1:0]    opX,
  input  logic [DW-1:0]    opY,
  output logic [DW-1:0]    result,
  output logic [CC_W-1:0]  condCode,
  output logic [ACC_W-1:0] accum
);

  // Wide enough for a DW x (DW+1) product plus one addend
  localparam int WW = 2 * DW + 2;
  localparam logic signed [WW-1:0] MAX_V = {{(WW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [WW-1:0] MIN_V = {{(WW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [WW-1:0] aExt, xExt, yExt, mExt, pExt, pTerm, term, sum;
  logic                 satHi, satLo, lessAY, pickX, satHit;
  logic [CC_W-1:0]      ccNext;
  logic [ACC_W-1:0]     accNext;

  always_comb begin
    aExt  = {{(WW-DW){opA[DW-1]}}, opA};
    xExt  = {{(WW-DW){opX[DW-1]}}, opX};
    yExt  = {{(WW-DW){opY[DW-1]}}, opY};
    mExt  = ctrl.useDiff ? (yExt - aExt) : yExt;
    pExt  = xExt * mExt;
    pTerm = ctrl.fracShift ? (pExt >>> (DW - 1)) : pExt;
    term  = ctrl.addMode ? (xExt + yExt) : (ctrl.negTerm ? -pTerm : pTerm);
    sum   = aExt + term;
    satHi = sum > MAX_V;
    satLo = sum < MIN_V;
  end

  always_comb begin
    lessAY = $signed(opA) < $signed(opY);
    pickX  = ctrl.cmpLess ? lessAY : !lessAY;
    satHit = 1'b0;
    unique case (ctrl.src)
      SRC_ARITH: begin
        if (ctrl.saturate && satHi) begin
          result = MAX_V[DW-1:0];
          satHit = 1'b1;
        end else if (ctrl.saturate && satLo) begin
          result = MIN_V[DW-1:0];
          satHit = 1'b1;
        end else if (ctrl.narrow) begin
          result = {sum[DW-2], sum[DW-2:0]};
        end else begin
          result = sum[DW-1:0];
        end
      end
      SRC_LOGIC: result = (opA & opX) ^ opY;
      SRC_CMP:   result = pickX ? opX : (ctrl.altInv ? ~opX : opY);
      default:   result = opA;
    endcase
  end

  always_comb begin
    ccNext              = '0;
    ccNext[CC_NORM]     = result[DW-1] ^ result[DW-2];
    ccNext[CC_BORROW]   = lessAY;
    ccNext[CC_MINUS]    = result[DW-1];
    ccNext[CC_ZERO]     = (result == '0);
    ccNext[CC_SAT]      = satHit;
    ccNext[CC_NONZERO]  = (result != '0);
    accNext             = accum + ACC_W'(pTerm);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accum    <= '0;
      condCode <= '0;
    end else if (en) begin
      condCode <= ccNext;
      if (ctrl.accLoad) accum <= accNext;
    end
  end

endmodule

// File: rtl/fx_alu.sv
module fx_alu
  import fx_alu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int ACC_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [3:0]       opcode,
  input  logic [DW-1:0]    opA,
  input  logic [DW-1:0]    opX,
  input  logic [DW-1:0]    opY,
  output logic [DW-1:0]    result,
  output logic [CC_W-1:0]  condCode,
  output logic [ACC_W-1:0] accum
);

  ctrl_t ctrl;

  fx_alu_ctrl u_ctrl (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  fx_alu_dp #(.DW(DW), .ACC_W(ACC_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .ctrl     (ctrl),
    .opA      (opA),
    .opX      (opX),
    .opY      (opY),
    .result   (result),
    .condCode (condCode),
    .accum    (accum)
  );

endmodule

// File: rtl/fx_alu_chk.sv
module fx_alu_chk
  import fx_alu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int ACC_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [3:0]       opcode,
  input logic [DW-1:0]    opA,
  input logic [DW-1:0]    result,
  input logic [CC_W-1:0]  condCode,
  input logic [ACC_W-1:0] accum
);

  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MAX = {1'b1, {(DW-1){1'b0}}};

  // R4: only an enabled 0x7 may move the accumulator
  assert_acc_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(en && opcode == 4'h7) |=> $stable(accum));

  // R8: opcodes owned by other blocks return A
  assert_pass_thru_R8: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'hC || opcode == 4'hD || opcode == 4'hF) |-> result == opA);

  // R9: a latched saturate flag means the latched result was a clamp value
  assert_sat_clamp_R9: assert property (@(posedge clk) disable iff (rst)
    en |=> (!condCode[CC_SAT] || $past(result) == POS_MAX || $past(result) == NEG_MAX));

  // R10: zero flag tracks the committed result
  assert_zero_flag_R10: assert property (@(posedge clk) disable iff (rst)
    en |=> condCode[CC_ZERO] == ($past(result) == '0));

  // R10: zero and nonzero never both set
  assert_zero_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({condCode[CC_ZERO], condCode[CC_NONZERO]}));

  // R11: nothing commits without en
  assert_en_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(condCode) && $stable(accum)));

endmodule

bind fx_alu fx_alu_chk #(.DW(DW), .ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .opcode   (opcode),
  .opA      (opA),
  .result   (result),
  .condCode (condCode),
  .accum    (accum)
);

// File: tb/tb_fx_alu.sv
module tb_fx_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [3:0]  opcode = 4'h0;
  logic [31:0] opA = '0, opX = '0, opY = '0;
  logic [31:0] result;
  logic [8:0]  condCode;
  logic [63:0] accum;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;  // 50 MHz

  fx_alu dut (
    .clk(clk), .rst(rst), .en(en), .opcode(opcode),
    .opA(opA), .opX(opX), .opY(opY),
    .result(result), .condCode(condCode), .accum(accum)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive inputs at falling edge; result settles before next rising edge
  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] x,
                       input logic [31:0] y, input logic e);
    @(negedge clk);
    opcode = op; opA = a; opX = x; opY = y; en = e;
    #1;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic tReset();
    chk("R12 reset acc", accum, 64'h0);
    chk("R12 reset cc", {55'h0, condCode}, 64'h0);
  endtask

  task automatic tAccum();
    drive(4'h7, 32'h55, 32'h4000_0000, 32'h4000_0000, 1'b1);
    chk("R4 op7 passes A", result, 32'h55);
    step();
    chk("R4 acc first add", accum, 64'h2000_0000);
    chk("R10 cc after op7", {55'h0, condCode}, 64'h102);
    drive(4'h7, 32'h55, 32'h4000_0000, 32'h4000_0000, 1'b1); step();
    chk("R4 acc second add", accum, 64'h4000_0000);
    drive(4'h7, 32'h0, 32'hFFFF_FFFF, 32'h1, 1'b1); step();
    chk("R4 acc adds floor of negative", accum, 64'h3FFF_FFFF);
    drive(4'h0, 32'h0, 32'h4000_0000, 32'h4000_0000, 1'b1); step();
    chk("R4 other opcode leaves acc", accum, 64'h3FFF_FFFF);
    drive(4'h7, 32'h0, 32'h4000_0000, 32'h4000_0000, 1'b0); step();
    chk("R11 acc holds when en low", accum, 64'h3FFF_FFFF);
  endtask

  task automatic tFracMac();
    drive(4'h0, 32'h1000_0000, 32'h4000_0000, 32'h4000_0000, 1'b0);
    chk("R1 op0 basic", result, 32'h3000_0000);
    drive(4'h1, 32'h1000_0000, 32'h4000_0000, 32'h4000_0000, 1'b0);
    chk("R1 op1 negated", result, 32'hF000_0000);
    drive(4'h0, 32'h0, 32'hFFFF_FFFF, 32'h1, 1'b0);
    chk("R1 op0 floor rounding", result, 32'hFFFF_FFFF);
    drive(4'h0, 32'h7000_0000, 32'h4000_0000, 32'h4000_0000, 1'b1);
    chk("R9 op0 clamps high", result, 32'h7FFF_FFFF);
    step();
    chk("R9 sat flag set", {55'h0, condCode}, 64'h111);
    drive(4'h2, 32'h7000_0000, 32'h4000_0000, 32'h4000_0000, 1'b0);
    chk("R1 op2 wraps", result, 32'h9000_0000);
    drive(4'h1, 32'h8000_0000, 32'h4000_0000, 32'h4000_0000, 1'b0);
    chk("R9 op1 clamps low", result, 32'h8000_0000);
    drive(4'h3, 32'h8000_0000, 32'h4000_0000, 32'h4000_0000, 1'b0);
    chk("R1 op3 wraps", result, 32'h6000_0000);
    drive(4'h0, 32'h0, 32'h8000_0000, 32'h8000_0000, 1'b0);
    chk("R1 op0 minus one squared clamps", result, 32'h7FFF_FFFF);
    drive(4'h2, 32'h0, 32'h8000_0000, 32'h8000_0000, 1'b0);
    chk("R1 op2 minus one squared wraps", result, 32'h8000_0000);
  endtask

  task automatic tIntMac();
    drive(4'h4, 32'd100, 32'd7, 32'hFFFF_FFFD, 1'b0);
    chk("R2 op4 signed product", result, 32'd79);
    drive(4'h4, 32'h7FFF_FFFF, 32'h1_0000, 32'h1_0000, 1'b0);
    chk("R2 op4 saturates", result, 32'h7FFF_FFFF);
    drive(4'h5, 32'h3FFF_FFFF, 32'h1, 32'h1, 1'b0);
    chk("R2 op5 31-bit wrap sign", result, 32'hC000_0000);
    drive(4'h5, 32'h0, 32'h1_0000, 32'h8000, 1'b1);
    chk("R2 op5 wraps to zero", result, 32'h0);
    step();
    chk("R10 zero flags", {55'h0, condCode}, 64'h00A);
    drive(4'h0, 32'h7000_0000, 32'h4000_0000, 32'h4000_0000, 1'b0);
    step();
    chk("R11 cc holds when en low", {55'h0, condCode}, 64'h00A);
    chk("R11 result live with en low", result, 32'h7FFF_FFFF);
  endtask

  task automatic tAdd3();
    drive(4'h6, 32'd1, 32'd2, 32'd3, 1'b0);
    chk("R3 add three", result, 32'd6);
    drive(4'h6, 32'h7FFF_FFFF, 32'h1, 32'h1, 1'b0);
    chk("R3 add clamps high", result, 32'h7FFF_FFFF);
    drive(4'h6, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    chk("R3 add clamps low", result, 32'h8000_0000);
    step();
    chk("R10 R9 cc for low clamp", {55'h0, condCode}, 64'h117);
  endtask

  task automatic tLogic();
    drive(4'h8, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0F0F_0000, 1'b0);
    chk("R5 and-xor", result, 32'hFF0F_F000);
  endtask

  task automatic tCompare();
    drive(4'h9, 32'd5, 32'h1234_5678, 32'd5, 1'b0);
    chk("R6 op9 equal picks X", result, 32'h1234_5678);
    drive(4'h9, 32'hFFFF_FFFF, 32'h1234_5678, 32'd1, 1'b0);
    chk("R6 op9 signed less picks ~X", result, 32'hEDCB_A987);
    drive(4'hA, 32'd3, 32'hAAAA_0000, 32'hFFFF_FFFE, 1'b0);
    chk("R6 opA ge picks X", result, 32'hAAAA_0000);
    drive(4'hA, 32'hFFFF_FFFE, 32'hAAAA_0000, 32'd3, 1'b0);
    chk("R6 opA lt picks Y", result, 32'd3);
    drive(4'hB, 32'hFFFF_FFFE, 32'hAAAA_0000, 32'd3, 1'b0);
    chk("R6 opB lt picks X", result, 32'hAAAA_0000);
    drive(4'hB, 32'd3, 32'hAAAA_0000, 32'd3, 1'b0);
    chk("R6 opB equal picks Y", result, 32'd3);
  endtask

  task automatic tInterp();
    drive(4'hE, 32'h0, 32'h4000_0000, 32'h4000_0000, 1'b0);
    chk("R7 interp from zero", result, 32'h2000_0000);
    drive(4'hE, 32'h2000_0000, 32'h4000_0000, 32'h6000_0000, 1'b0);
    chk("R7 interp midpoint", result, 32'h4000_0000);
    drive(4'hE, 32'h8000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0);
    chk("R7 interp wide difference", result, 32'h7FFF_FFFD);
    drive(4'hE, 32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0000, 1'b0);
    chk("R7 interp clamps", result, 32'h7FFF_FFFF);
  endtask

  task automatic tPassThru();
    logic [63:0] accBefore;
    accBefore = accum;
    drive(4'hC, 32'hCAFE_0001, 32'h4000_0000, 32'h4000_0000, 1'b1);
    chk("R8 opC passes A", result, 32'hCAFE_0001);
    step();
    drive(4'hD, 32'hCAFE_0002, 32'h4000_0000, 32'h4000_0000, 1'b1);
    chk("R8 opD passes A", result, 32'hCAFE_0002);
    step();
    drive(4'hF, 32'hCAFE_0003, 32'h4000_0000, 32'h4000_0000, 1'b1);
    chk("R8 opF passes A", result, 32'hCAFE_0003);
    step();
    chk("R8 acc unchanged", accum, accBefore);
  endtask

  task automatic tMidReset();
    drive(4'h7, 32'h1, 32'h4000_0000, 32'h4000_0000, 1'b1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R12 sync reset acc", accum, 64'h0);
    chk("R12 sync reset cc", {55'h0, condCode}, 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset();
    @(negedge clk);
    rst = 1'b0;
    tAccum();
    tFracMac();
    tIntMac();
    tAdd3();
    tLogic();
    tCompare();
    tInterp();
    tPassThru();
    tMidReset();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #2_000_000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule